// File: doc/BRIEF.md
# System-Call Monitor with Run Statistics

This unit sits beside a processor core. It watches every instruction word the core retires. When the retired word is the system-call encoding, it reads the service number and the first argument, which the core supplies from its register file. Service 1 prints an integer: the unit raises a one-cycle strobe and presents the 32-bit argument. Service 10 ends the run: the unit raises a sticky stop flag that the core uses to freeze itself.

Two saturating counters track the run. One counts clock cycles since reset and the other counts retired instructions. Both freeze when the stop flag rises, so the core's environment can read them afterwards and form an instructions-per-clock figure. The ratio itself is not computed here. The core is expected to drive the service input from register 2 and the argument input from register 4.

Top module: `syscall_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are zero from that edge on: `print_vld`, `print_data`, `halt`, `cycle_count` and `instr_count`.
- R2: A system call is recognised only on a cycle with `retire_vld` high and `retire_instr` exactly equal to 32'h0000000C. Any other word, or that word with `retire_vld` low, causes no print and no stop.
- R3: A recognised call with `svc_num` equal to 1, while not halted, makes `print_vld` high for exactly the one cycle after the retire edge, with `print_data` equal to the `svc_arg` sampled at that edge. Back-to-back calls give back-to-back strobes. `print_data` otherwise holds its last value.
- R4: A recognised call with `svc_num` equal to 10 (the full 32-bit value must match) sets `halt` from the next cycle. `halt` then stays high until reset.
- R5: A recognised call with any other service number causes no print and no stop. It still counts as one retired instruction.
- R6: `cycle_count` increases by one at every rising edge with `rst` low and `halt` low. This includes the edge that captures the stop call. It is frozen while `halt` is high.
- R7: `instr_count` increases by one at every rising edge with `rst` low, `halt` low and `retire_vld` high. The stop call itself is counted.
- R8: While `halt` is high, retired instructions are ignored. They cause no print, no count and no change to `print_data`.
- R9: Each counter stops at 2^CNT_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_instr | input | 32 | Word of the retiring instruction |
| svc_num | input | 32 | Service-number register value |
| svc_arg | input | 32 | First-argument register value |
| print_vld | output | 1 | One-cycle strobe for an integer to print |
| print_data | output | 32 | Integer to print |
| halt | output | 1 | Sticky stop flag |
| cycle_count | output | CNT_W | Clock cycles since reset, frozen at stop |
| instr_count | output | CNT_W | Retired instructions, frozen at stop |

## Verification
A wrong decode shows up one cycle after the offending retire. It appears as an extra or missing print strobe, a stray or missing stop flag, or wrong print data. A gating fault in either counter shows within one cycle as a count that differs from the model, and it never heals, because the counts only grow or hold. A fault in the stop latch or the freeze logic shows in the first cycle after the stop: either the flag drops, or a count still moves. A saturation fault shows on the cycle after the maximum is reached, as a wrap to zero.

// File: rtl/sysmon_pkg.sv
package sysmon_pkg;

    localparam int          DATA_W        = 32;
    localparam logic [31:0] SYSCALL_WORD  = 32'h0000_000C;
    localparam logic [31:0] SVC_PRINT_INT = 32'd1;
    localparam logic [31:0] SVC_EXIT      = 32'd10;

    typedef enum logic [1:0] {
        EVT_NONE,
        EVT_PRINT,
        EVT_EXIT,
        EVT_OTHER
    } svc_kind_e;

    typedef struct packed {
        logic      retired;
        svc_kind_e kind;
    } retire_evt_t;

    function automatic svc_kind_e classify(
        input logic              vld,
        input logic [DATA_W-1:0] word,
        input logic [DATA_W-1:0] svc
    );
        svc_kind_e k;
        if (!vld || word != SYSCALL_WORD) begin
            k = EVT_NONE;
        end else if (svc == SVC_PRINT_INT) begin
            k = EVT_PRINT;
        end else if (svc == SVC_EXIT) begin
            k = EVT_EXIT;
        end else begin
            k = EVT_OTHER;
        end
        return k;
    endfunction

endpackage

// File: rtl/sysmon_decode.sv
module sysmon_decode
    import sysmon_pkg::*;
(
    input  logic              halted,
    input  logic              retire_vld,
    input  logic [DATA_W-1:0] retire_instr,
    input  logic [DATA_W-1:0] svc_num,
    output retire_evt_t       evt
);
    logic live;

    // Nothing retires once the core is frozen.
    assign live = retire_vld && !halted;

    always_comb begin
        evt.retired = live;
        evt.kind    = classify(live, retire_instr, svc_num);
    end

endmodule

// File: rtl/sysmon_counter.sv
module sysmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (en && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count == TOP |=> count == TOP); // R9

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count)); // R6

endmodule

// File: rtl/sysmon_effects.sv
module sysmon_effects
    import sysmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  retire_evt_t       evt,
    input  logic [DATA_W-1:0] svc_arg,
    output logic              print_vld,
    output logic [DATA_W-1:0] print_data,
    output logic              halt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            print_vld  <= 1'b0;
            print_data <= '0;
            halt       <= 1'b0;
        end else begin
            print_vld <= (evt.kind == EVT_PRINT);
            if (evt.kind == EVT_PRINT) begin
                print_data <= svc_arg;
            end
            if (evt.kind == EVT_EXIT) begin
                halt <= 1'b1;
            end
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt); // R4

    AST_QUIET_AFTER_HALT: assert property (@(posedge clk) disable iff (rst)
        halt |=> !print_vld && $stable(print_data)); // R8

endmodule

// File: rtl/syscall_monitor.sv
module syscall_monitor
    import sysmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              retire_vld,
    input  logic [31:0]       retire_instr,
    input  logic [31:0]       svc_num,
    input  logic [31:0]       svc_arg,
    output logic              print_vld,
    output logic [31:0]       print_data,
    output logic              halt,
    output logic [CNT_W-1:0]  cycle_count,
    output logic [CNT_W-1:0]  instr_count
);
    retire_evt_t evt;
    logic        cyc_en;

    sysmon_decode u_decode (
        .halted       (halt),
        .retire_vld   (retire_vld),
        .retire_instr (retire_instr),
        .svc_num      (svc_num),
        .evt          (evt)
    );

    sysmon_effects u_effects (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .svc_arg    (svc_arg),
        .print_vld  (print_vld),
        .print_data (print_data),
        .halt       (halt)
    );

    assign cyc_en = !halt;

    sysmon_counter #(.W(CNT_W)) u_cycles (
        .clk   (clk),
        .rst   (rst),
        .en    (cyc_en),
        .count (cycle_count)
    );

    sysmon_counter #(.W(CNT_W)) u_retired (
        .clk   (clk),
        .rst   (rst),
        .en    (evt.retired),
        .count (instr_count)
    );

    AST_PRINT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        print_vld |-> $past(retire_vld && retire_instr == SYSCALL_WORD
                            && svc_num == SVC_PRINT_INT)); // R3

    AST_PRINT_VALUE: assert property (@(posedge clk) disable iff (rst)
        print_vld |-> print_data == $past(svc_arg)); // R3

    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(halt) |-> $past(retire_vld && retire_instr == SYSCALL_WORD
                              && svc_num == SVC_EXIT)); // R4

    AST_CYCLES_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(cycle_count)); // R6

    AST_RETIRED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (halt || !retire_vld) |=> $stable(instr_count)); // R7

endmodule

// File: tb/test_syscall_monitor.sv
`timescale 1ns/1ps
module test_syscall_monitor;
    localparam int    CW   = 12;
    localparam longint MAXC = (longint'(1) << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          retire_vld = 1'b0;
    logic [31:0]   retire_instr = '0;
    logic [31:0]   svc_num = '0;
    logic [31:0]   svc_arg = '0;
    logic          print_vld;
    logic [31:0]   print_data;
    logic          halt;
    logic [CW-1:0] cycle_count;
    logic [CW-1:0] instr_count;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #2.5 clk = ~clk;

    syscall_monitor #(.CNT_W(CW)) i_syscall_monitor (
        .clk(clk), .rst(rst), .retire_vld(retire_vld), .retire_instr(retire_instr),
        .svc_num(svc_num), .svc_arg(svc_arg), .print_vld(print_vld),
        .print_data(print_data), .halt(halt), .cycle_count(cycle_count),
        .instr_count(instr_count)
    );

    // Behavioural reference
    bit      m_pv, m_halt, m_rst_seen;
    longint  m_pd, m_cyc, m_ins;
    initial begin
        m_pv = 0; m_halt = 0; m_pd = 0; m_cyc = 0; m_ins = 0; m_rst_seen = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_pv = 0; m_halt = 0; m_pd = 0; m_cyc = 0; m_ins = 0; m_rst_seen = 1;
        end else begin
            m_rst_seen = 0;
            m_pv = 0;
            if (!m_halt) begin
                if (m_cyc < MAXC) m_cyc++;
                if (retire_vld) begin
                    if (m_ins < MAXC) m_ins++;
                    if (retire_instr == 32'h0000000C) begin
                        if (svc_num == 32'd1) begin
                            m_pv = 1; m_pd = longint'(svc_arg);
                        end else if (svc_num == 32'd10) begin
                            m_halt = 1;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk(m_rst_seen ? "R1" : "R3", "print_vld",   longint'(print_vld),  longint'(m_pv));
            chk(m_rst_seen ? "R1" : "R3", "print_data",  longint'(print_data), m_pd);
            chk(m_rst_seen ? "R1" : "R4", "halt",        longint'(halt),       longint'(m_halt));
            chk(m_rst_seen ? "R1" : "R6", "cycle_count", longint'(cycle_count), m_cyc);
            chk(m_rst_seen ? "R1" : "R7", "instr_count", longint'(instr_count), m_ins);
        end
    end

    task automatic drive(input bit v, input logic [31:0] w, input logic [31:0] s, input logic [31:0] a);
        @(negedge clk);
        retire_vld = v; retire_instr = w; svc_num = s; svc_arg = a;
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #900000;
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        longint c0, i0;
        // Reset with a print call presented: must be ignored
        rst = 1'b1;
        drive(1, 32'h0000000C, 32'd1, 32'd99);
        drive(1, 32'h0000000C, 32'd10, 32'd0);
        settle();
        chk("R1", "print_vld in reset", longint'(print_vld), 0);
        chk("R1", "halt in reset", longint'(halt), 0);
        chk("R1", "cycle_count in reset", longint'(cycle_count), 0);
        drive(0, 0, 0, 0);
        rst = 1'b0;

        // Near-miss words and a non-retiring syscall
        drive(1, 32'h0000000D, 32'd1, 32'd5);
        settle(); chk("R2", "print on 0x0D", longint'(print_vld), 0);
        drive(1, 32'h0C000000, 32'd1, 32'd5);
        settle(); chk("R2", "print on 0x0C000000", longint'(print_vld), 0);
        drive(1, 32'h1000000C, 32'd10, 32'd5);
        settle(); chk("R2", "halt on 0x1000000C", longint'(halt), 0);
        drive(0, 32'h0000000C, 32'd1, 32'd5);
        settle(); chk("R2", "print without retire", longint'(print_vld), 0);
        drive(0, 0, 0, 0);

        // Print calls, including back to back
        drive(1, 32'h0000000C, 32'd1, 32'd42);
        settle();
        chk("R3", "strobe", longint'(print_vld), 1);
        chk("R3", "data 42", longint'(print_data), 42);
        drive(1, 32'h0000000C, 32'd1, 32'hFFFF_FFF9);
        drive(1, 32'h0000000C, 32'd1, 32'd7);
        settle(); chk("R3", "second strobe data", longint'(print_data), 7);
        drive(0, 32'h0000000C, 32'd1, 32'd1234);
        settle();
        chk("R3", "strobe ends", longint'(print_vld), 0);
        chk("R3", "data held", longint'(print_data), 7);

        // Other services
        i0 = longint'(instr_count);
        drive(1, 32'h0000000C, 32'd4, 32'd77);
        drive(1, 32'h0000000C, 32'h0000010A, 32'd77);
        settle();
        chk("R5", "no print", longint'(print_vld), 0);
        chk("R5", "no halt", longint'(halt), 0);
        chk("R5", "counted", longint'(instr_count), i0 + 2);
        drive(0, 0, 0, 0);

        // Stop call
        drive(1, 32'h0000000C, 32'd10, 32'd0);
        settle();
        chk("R4", "halt set", longint'(halt), 1);
        c0 = longint'(cycle_count); i0 = longint'(instr_count);
        for (int k = 0; k < 6; k++) drive(1, 32'h0000000C, 32'd1, 32'd555);
        drive(0, 0, 0, 0);
        settle();
        chk("R8", "no print when halted", longint'(print_vld), 0);
        chk("R8", "data unchanged", longint'(print_data), 7);
        chk("R8", "instr frozen", longint'(instr_count), i0);
        chk("R6", "cycles frozen", longint'(cycle_count), c0);
        chk("R4", "halt sticky", longint'(halt), 1);

        // Reset, then saturation
        rst = 1'b1;
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        settle(); chk("R1", "halt cleared", longint'(halt), 0);
        rst = 1'b0;
        for (int k = 0; k < 4200; k++) drive(1, 32'h00000020, 32'd0, 32'd0);
        settle();
        chk("R9", "cycle saturates", longint'(cycle_count), MAXC);
        chk("R9", "instr saturates", longint'(instr_count), MAXC);
        drive(1, 32'h0000000C, 32'd10, 32'd0);
        settle();
        chk("R4", "halt at max", longint'(halt), 1);
        chk("R9", "still max", longint'(cycle_count), MAXC);
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        finish_run();
    end

endmodule